// File: doc/BRIEF.md
# I/O Virtual Address Table Walker

This block turns a 32-bit I/O virtual address into a physical address by reading a two-level translation table from memory. A client presents one request at a time: an address and a read/write flag. The walker first reads a directory entry. It then reads a page entry and returns the physical page base joined with the untouched page offset, together with the six cache-attribute bits of the page entry. It does not interpret those bits. When the paging-enable input is low, the address is returned unchanged one cycle after it is accepted.

Table reads use a plain memory port. The walker issues a one-cycle request pulse carrying a word address and waits for a response that carries data and an error flag. A missing mapping or a forbidden access raises a page fault. The fault records the virtual address and the access direction, and the walker accepts nothing more until software pulses fault-done. The faulting request then completes with a fault response. A memory error during either read ends the walk with a bus-error response and a one-cycle bus-error event, and no fault is recorded.

Top module: `iova_walker`

## Requirements
- R1: While reset is applied and after its release, before any request, `req_ready` is 1 and `rsp_valid`, `mem_req_valid`, `fault_pending` and `bus_err_evt` are 0.
- R2: With `paging_en` low, an accepted request gives `rsp_valid` for one cycle on the next cycle, with `rsp_paddr` equal to `req_addr`, `rsp_attr`, `rsp_fault` and `rsp_buserr` all 0, and no memory request.
- R3: With `paging_en` high, an accepted request issues a one-cycle `mem_req_valid` on the next cycle. Its address is `{dir_base[31:12], 12'h000}` plus 4 times virtual address bits 31:22. Bits 11:0 of `dir_base` have no effect.
- R4: A directory entry with bit 0 set, returned without error, issues the page-entry read on the following cycle. Its address is `{entry[31:12], 12'h000}` plus 4 times virtual address bits 21:12.
- R5: A page entry with bit 0 set and the needed permission gives `rsp_valid` on the following cycle. `rsp_paddr` is `{entry[31:12], va[11:0]}`, `rsp_attr` is entry bits 8:3, and `rsp_fault` and `rsp_buserr` are 0.
- R6: A directory or page entry with bit 0 clear raises `fault_pending` on the following cycle. `fault_addr` holds the virtual address and `fault_write` holds the request's write flag. No response is given yet.
- R7: A read (`req_write`=0) to a page entry with bit 1 clear, or a write to a page entry with bit 2 clear, faults exactly as in R6.
- R8: While `fault_pending` is 1, `req_ready` is 0 and requests are ignored. A `fault_done` pulse clears `fault_pending` on the next cycle, and in that same cycle the walker gives a one-cycle response with `rsp_fault`=1 and `rsp_paddr`=0.
- R9: A response with `mem_rsp_err` set gives, on the next cycle, `rsp_valid` with `rsp_buserr`=1, `rsp_fault`=0 and `rsp_paddr`=0, plus a one-cycle `bus_err_evt`. No fault is recorded, whatever data comes with the error.
- R10: While a walk is in progress, `req_ready` is 0 and requests are ignored. A `fault_done` pulse with no fault pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| paging_en | input | 1 | Translation enable; low means pass-through |
| dir_base | input | 32 | Directory base address (bits 31:12 used) |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_ready | output | 1 | Walker can accept a request |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault or bus error) |
| rsp_attr | output | 6 | Page entry bits 8:3, passed through |
| rsp_fault | output | 1 | Request ended in a page fault |
| rsp_buserr | output | 1 | Request ended in a bus error |
| mem_req_valid | output | 1 | One-cycle table read request |
| mem_req_addr | output | 32 | Byte address of the entry read |
| mem_rsp_valid | input | 1 | Table read response strobe |
| mem_rsp_data | input | 32 | Entry word read |
| mem_rsp_err | input | 1 | Read error flag |
| fault_pending | output | 1 | A page fault awaits acknowledgement |
| fault_addr | output | 32 | Faulting virtual address |
| fault_write | output | 1 | Faulting access was a write |
| fault_done | input | 1 | Fault acknowledgement pulse |
| bus_err_evt | output | 1 | One-cycle bus-error event |

## Verification
Two collisions matter here. The first is a read response that carries both the error flag and an entry whose valid bit is clear. This is provoked by marking a table word as erroring while it is left zero, and the response must be a bus error with no fault latched. The second is a new request that is already waiting when the `fault_done` pulse arrives. It is provoked by holding `req_valid` through the whole fault hold, and the bench checks that the request is taken only on the cycle after the fault response, never on the cycle of the pulse. A behavioural model in the bench predicts every output on every cycle, with memory latencies of one and three cycles.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_DIR  = 2'd1,
    WS_PTE  = 2'd2,
    WS_HOLD = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    EO_NEXT   = 2'd0,
    EO_FAULT  = 2'd1,
    EO_BUSERR = 2'd2
  } entry_out_e;

  // Entry word bit positions that the walk decodes
  localparam int unsigned ENT_VALID_BIT = 0;
  localparam int unsigned ENT_RD_BIT    = 1;
  localparam int unsigned ENT_WR_BIT    = 2;
  localparam int unsigned ENT_ATTR_LSB  = 3;
  localparam int unsigned ENT_ATTR_W    = 6;
  localparam int unsigned ENT_FLAG_W    = 3;

endpackage

// File: rtl/walk_addr_gen.sv
module walk_addr_gen #(
  parameter int unsigned DIR_IDX_W = 10,
  parameter int unsigned TBL_IDX_W = 10,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned ENT_LOG2  = 2
) (
  input  logic [DIR_IDX_W+TBL_IDX_W+OFF_W-1:0] va,
  input  logic [DIR_IDX_W+TBL_IDX_W-1:0]       dir_page,
  input  logic [DIR_IDX_W+TBL_IDX_W-1:0]       tbl_page,
  output logic [DIR_IDX_W+TBL_IDX_W+OFF_W-1:0] dir_ent_addr,
  output logic [DIR_IDX_W+TBL_IDX_W+OFF_W-1:0] tbl_ent_addr
);
  localparam int unsigned VA_W = DIR_IDX_W + TBL_IDX_W + OFF_W;

  logic [VA_W-1:0] dir_off;
  logic [VA_W-1:0] tbl_off;

  always_comb begin
    dir_off      = VA_W'(va[VA_W-1 -: DIR_IDX_W]) << ENT_LOG2;
    tbl_off      = VA_W'(va[OFF_W +: TBL_IDX_W]) << ENT_LOG2;
    dir_ent_addr = {dir_page, {OFF_W{1'b0}}} + dir_off;
    tbl_ent_addr = {tbl_page, {OFF_W{1'b0}}} + tbl_off;
  end

endmodule

// File: rtl/walk_entry_chk.sv
module walk_entry_chk
  import walk_pkg::*;
(
  input  logic [ENT_FLAG_W-1:0] ent_flags,
  input  logic                  rd_err,
  input  logic                  leaf,
  input  logic                  is_write,
  output entry_out_e            outcome
);
  logic perm_ok;

  always_comb begin
    perm_ok = is_write ? ent_flags[ENT_WR_BIT] : ent_flags[ENT_RD_BIT];
    if (rd_err) begin
      outcome = EO_BUSERR;
    end else if (!ent_flags[ENT_VALID_BIT]) begin
      outcome = EO_FAULT;
    end else if (leaf && !perm_ok) begin
      outcome = EO_FAULT;
    end else begin
      outcome = EO_NEXT;
    end
  end

endmodule

// File: rtl/walk_fault_reg.sv
module walk_fault_reg #(
  parameter int unsigned VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap,
  input  logic [VA_W-1:0] cap_addr,
  input  logic            cap_write,
  input  logic            done,
  output logic            pending,
  output logic [VA_W-1:0] addr,
  output logic            write
);
  logic pend_d;

  always_comb begin
    pend_d = pending;
    if (cap) begin
      pend_d = 1'b1;
    end else if (done) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else begin
      pending <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      write <= 1'b0;
    end else if (cap) begin
      addr  <= cap_addr;
      write <= cap_write;
    end
  end

  assert_fault_info_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !cap) |=> ($stable(addr) && $stable(write)));

endmodule

// File: rtl/iova_walker.sv
module iova_walker
  import walk_pkg::*;
#(
  parameter int unsigned DIR_IDX_W = 10,
  parameter int unsigned TBL_IDX_W = 10,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned ENT_LOG2  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  paging_en,
  input  logic [31:0]           dir_base,
  input  logic                  req_valid,
  input  logic [31:0]           req_addr,
  input  logic                  req_write,
  output logic                  req_ready,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_paddr,
  output logic [ENT_ATTR_W-1:0] rsp_attr,
  output logic                  rsp_fault,
  output logic                  rsp_buserr,
  output logic                  mem_req_valid,
  output logic [31:0]           mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [31:0]           mem_rsp_data,
  input  logic                  mem_rsp_err,
  output logic                  fault_pending,
  output logic [31:0]           fault_addr,
  output logic                  fault_write,
  input  logic                  fault_done,
  output logic                  bus_err_evt
);
  localparam int unsigned VA_W   = DIR_IDX_W + TBL_IDX_W + OFF_W;
  localparam int unsigned PAGE_W = VA_W - OFF_W;
  localparam int unsigned GAP_LSB = ENT_ATTR_LSB + ENT_ATTR_W;

  walk_state_e st_q, st_d;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic            accept;

  logic [VA_W-1:0] dir_ent_addr, tbl_ent_addr;
  entry_out_e      outcome;
  logic            cap;

  logic                  mrv_d;
  logic [VA_W-1:0]       mra_d;
  logic                  rv_d;
  logic [VA_W-1:0]       rpa_d;
  logic [ENT_ATTR_W-1:0] rat_d;
  logic                  rf_d, rb_d, be_d;

  logic unused_bits;
  assign unused_bits = ^{dir_base[OFF_W-1:0], mem_rsp_data[OFF_W-1:GAP_LSB]};

  assign req_ready = (st_q == WS_IDLE);
  assign accept    = req_ready && req_valid;

  walk_addr_gen #(
    .DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W),
    .OFF_W(OFF_W), .ENT_LOG2(ENT_LOG2)
  ) u_addr (
    .va          ((st_q == WS_IDLE) ? req_addr : va_q),
    .dir_page    (dir_base[VA_W-1:OFF_W]),
    .tbl_page    (mem_rsp_data[VA_W-1:OFF_W]),
    .dir_ent_addr(dir_ent_addr),
    .tbl_ent_addr(tbl_ent_addr)
  );

  walk_entry_chk u_chk (
    .ent_flags(mem_rsp_data[ENT_FLAG_W-1:0]),
    .rd_err   (mem_rsp_err),
    .leaf     (st_q == WS_PTE),
    .is_write (wr_q),
    .outcome  (outcome)
  );

  walk_fault_reg #(.VA_W(VA_W)) u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap),
    .cap_addr (va_q),
    .cap_write(wr_q),
    .done     (fault_done),
    .pending  (fault_pending),
    .addr     (fault_addr),
    .write    (fault_write)
  );

  // Next-state and output-load decode
  always_comb begin
    st_d  = st_q;
    mrv_d = 1'b0;
    mra_d = (st_q == WS_IDLE) ? dir_ent_addr : tbl_ent_addr;
    rv_d  = 1'b0;
    rpa_d = '0;
    rat_d = '0;
    rf_d  = 1'b0;
    rb_d  = 1'b0;
    be_d  = 1'b0;
    cap   = 1'b0;
    unique case (st_q)
      WS_IDLE: begin
        if (req_valid) begin
          if (!paging_en) begin
            rv_d  = 1'b1;
            rpa_d = req_addr;
          end else begin
            st_d  = WS_DIR;
            mrv_d = 1'b1;
          end
        end
      end
      WS_DIR, WS_PTE: begin
        if (mem_rsp_valid) begin
          unique case (outcome)
            EO_BUSERR: begin
              st_d = WS_IDLE;
              rv_d = 1'b1;
              rb_d = 1'b1;
              be_d = 1'b1;
            end
            EO_FAULT: begin
              st_d = WS_HOLD;
              cap  = 1'b1;
            end
            default: begin
              if (st_q == WS_DIR) begin
                st_d  = WS_PTE;
                mrv_d = 1'b1;
              end else begin
                st_d  = WS_IDLE;
                rv_d  = 1'b1;
                rpa_d = {mem_rsp_data[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
                rat_d = mem_rsp_data[ENT_ATTR_LSB +: ENT_ATTR_W];
              end
            end
          endcase
        end
      end
      WS_HOLD: begin
        if (fault_done) begin
          st_d = WS_IDLE;
          rv_d = 1'b1;
          rf_d = 1'b1;
        end
      end
      default: st_d = WS_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= WS_IDLE;
      mem_req_valid <= 1'b0;
      rsp_valid     <= 1'b0;
      bus_err_evt   <= 1'b0;
    end else begin
      st_q          <= st_d;
      mem_req_valid <= mrv_d;
      rsp_valid     <= rv_d;
      bus_err_evt   <= be_d;
    end
  end

  // Request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q <= '0;
      wr_q <= 1'b0;
    end else if (accept) begin
      va_q <= req_addr;
      wr_q <= req_write;
    end
  end

  // Memory address, enabled when a read is issued
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_addr <= '0;
    end else if (mrv_d) begin
      mem_req_addr <= mra_d;
    end
  end

  // Response payload, enabled when a response is issued
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_paddr  <= '0;
      rsp_attr   <= '0;
      rsp_fault  <= 1'b0;
      rsp_buserr <= 1'b0;
    end else if (rv_d) begin
      rsp_paddr  <= rpa_d;
      rsp_attr   <= rat_d;
      rsp_fault  <= rf_d;
      rsp_buserr <= rb_d;
    end
  end

  assert_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !paging_en) |=> (rsp_valid && rsp_paddr == $past(req_addr) && !mem_req_valid));

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pending |-> !req_ready);

  assert_fault_rsp_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_pending) |-> (rsp_valid && rsp_fault && !rsp_buserr));

  assert_buserr_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_evt |-> (rsp_valid && rsp_buserr && !rsp_fault && !fault_pending));

endmodule

// File: tb/test_iova_walker.sv
module test_iova_walker;
  logic        clk, rst_n;
  logic        paging_en;
  logic [31:0] dir_base;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_write;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [5:0]  rsp_attr;
  logic        rsp_fault, rsp_buserr;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        mem_rsp_err;
  logic        fault_pending;
  logic [31:0] fault_addr;
  logic        fault_write;
  logic        fault_done;
  logic        bus_err_evt;

  iova_walker i_iova_walker (
    .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_base(dir_base),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_attr(rsp_attr), .rsp_fault(rsp_fault), .rsp_buserr(rsp_buserr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err), .fault_pending(fault_pending),
    .fault_addr(fault_addr), .fault_write(fault_write),
    .fault_done(fault_done), .bus_err_evt(bus_err_evt)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_tag = "R1";
  int    mem_lat = 1;

  bit [31:0] mem_words [bit [31:0]];
  bit        err_words [bit [31:0]];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input string name,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, name, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] rd_word(input bit [31:0] a);
    return mem_words.exists(a) ? mem_words[a] : 32'h0;
  endfunction

  function automatic bit rd_err(input bit [31:0] a);
    return err_words.exists(a) ? err_words[a] : 1'b0;
  endfunction

  // Memory responder: fixed latency, inputs changed at the falling edge
  initial begin
    int        cnt = 0;
    bit [31:0] ma  = 0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
    mem_rsp_err   = 1'b0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      mem_rsp_data  = 32'hDEAD_0000;
      if (!rst_n) begin
        cnt = 0;
      end else begin
        if (cnt > 0) begin
          cnt--;
          if (cnt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd_word(ma);
            mem_rsp_err   = rd_err(ma);
          end
        end
        if (mem_req_valid) begin
          ma  = mem_req_addr;
          cnt = mem_lat;
        end
      end
    end
  end

  // Behavioural reference: expected port values after each rising edge
  int        m_st = 0;
  bit [31:0] m_va = 0;
  bit        m_wr = 0;
  bit        e_rv = 0, e_rf = 0, e_rb = 0, e_mrv = 0, e_fp = 0, e_fw = 0, e_be = 0;
  bit [31:0] e_pa = 0, e_ma = 0, e_fa = 0;
  bit [5:0]  e_at = 0;

  initial begin
    forever begin
      @(posedge clk);
      e_rv = 0; e_mrv = 0; e_be = 0;
      if (!rst_n) begin
        m_st = 0; e_fp = 0;
      end else begin
        case (m_st)
          0: if (req_valid) begin
            if (!paging_en) begin
              e_rv = 1; e_pa = req_addr; e_at = 0; e_rf = 0; e_rb = 0;
            end else begin
              m_va = req_addr; m_wr = req_write; m_st = 1; e_mrv = 1;
              e_ma = (dir_base & 32'hFFFF_F000) + ((req_addr >> 22) << 2);
            end
          end
          1, 2: if (mem_rsp_valid) begin
            bit [31:0] d;
            bit        bad;
            d = mem_rsp_data;
            bad = !d[0];
            if (m_st == 2) bad = bad || (m_wr ? !d[2] : !d[1]);
            if (mem_rsp_err) begin
              e_rv = 1; e_rb = 1; e_rf = 0; e_pa = 0; e_at = 0; e_be = 1; m_st = 0;
            end else if (bad) begin
              e_fp = 1; e_fa = m_va; e_fw = m_wr; m_st = 3;
            end else if (m_st == 1) begin
              e_mrv = 1; m_st = 2;
              e_ma = (d & 32'hFFFF_F000) + (((m_va >> 12) & 32'h3FF) << 2);
            end else begin
              e_rv = 1; e_rf = 0; e_rb = 0; m_st = 0;
              e_pa = (d & 32'hFFFF_F000) | (m_va & 32'hFFF);
              e_at = 6'((d >> 3) & 32'h3F);
            end
          end
          default: if (fault_done) begin
            e_fp = 0; e_rv = 1; e_rf = 1; e_rb = 0; e_pa = 0; e_at = 0; m_st = 0;
          end
        endcase
      end
    end
  end

  // Per-cycle comparison at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      check(cur_tag, "req_ready", {31'b0, req_ready}, {31'b0, (m_st == 0)});
      check(cur_tag, "rsp_valid", {31'b0, rsp_valid}, {31'b0, e_rv});
      if (e_rv) begin
        check(cur_tag, "rsp_paddr", rsp_paddr, e_pa);
        check(cur_tag, "rsp_attr", {26'b0, rsp_attr}, {26'b0, e_at});
        check(cur_tag, "rsp_fault", {31'b0, rsp_fault}, {31'b0, e_rf});
        check(cur_tag, "rsp_buserr", {31'b0, rsp_buserr}, {31'b0, e_rb});
      end
      check(cur_tag, "mem_req_valid", {31'b0, mem_req_valid}, {31'b0, e_mrv});
      if (e_mrv) check(cur_tag, "mem_req_addr", mem_req_addr, e_ma);
      check(cur_tag, "fault_pending", {31'b0, fault_pending}, {31'b0, e_fp});
      if (e_fp) begin
        check(cur_tag, "fault_addr", fault_addr, e_fa);
        check(cur_tag, "fault_write", {31'b0, fault_write}, {31'b0, e_fw});
      end
      check(cur_tag, "bus_err_evt", {31'b0, bus_err_evt}, {31'b0, e_be});
    end
  end

  task automatic send(input logic [31:0] a, input logic w);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_walk();
    while (!(req_ready || fault_pending)) @(negedge clk);
    if (fault_pending) begin
      repeat (2) @(negedge clk);
      fault_done = 1'b1;
      @(negedge clk);
      fault_done = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic walk(input logic [31:0] a, input logic w);
    send(a, w);
    finish_walk();
    @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; paging_en = 1'b0; dir_base = 32'h0010_0ABC;
    req_valid = 1'b0; req_addr = 0; req_write = 0; fault_done = 1'b0;
    // Table contents
    mem_words[32'h0010_0004] = 32'h0020_0001;   // dir idx 1 -> table 0x200000
    mem_words[32'h0020_0004] = 32'hABCD_E1FF;   // rw page, all attr bits set
    mem_words[32'h0020_0014] = 32'h7654_3005;   // write-only page
    mem_words[32'h0010_0FFC] = 32'h0030_0001;   // dir idx 0x3FF
    mem_words[32'h0030_000C] = 32'h1234_500B;   // read-only page, override bit
    err_words[32'h0010_0010] = 1'b1;            // dir idx 4 errors (data 0)
    err_words[32'h0020_000C] = 1'b1;            // table idx 3 errors

    // R1: reset state
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    check("R1", "req_ready_in_reset", {31'b0, req_ready}, 32'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "fault_pending_after_reset", {31'b0, fault_pending}, 32'd0);

    // R2: pass-through
    cur_tag = "R2";
    walk(32'h1234_5678, 1'b0);
    walk(32'hFFFF_FFFF, 1'b1);

    paging_en = 1'b1;
    for (int lat = 1; lat <= 3; lat += 2) begin
      mem_lat = lat;
      // R3 R4 R5: full walks, read and write, low and high indices
      cur_tag = "R5";
      walk(32'h0040_1234, 1'b0);
      walk(32'h0040_1234, 1'b1);
      cur_tag = "R3";
      walk(32'hFFC0_3ABC, 1'b0);
      // R7: write to read-only page, read from write-only page
      cur_tag = "R7";
      walk(32'hFFC0_3ABC, 1'b1);
      walk(32'h0040_5000, 1'b0);
      cur_tag = "R4";
      walk(32'h0040_5FFF, 1'b1);
      // R6: invalid directory entry, invalid page entry
      cur_tag = "R6";
      walk(32'h0080_0123, 1'b1);
      walk(32'h0040_2000, 1'b0);
      // R9: error on directory read with invalid data, error on table read
      cur_tag = "R9";
      walk(32'h0100_0000, 1'b0);
      walk(32'h0040_3000, 1'b1);
    end

    // R8: request held through fault hold and the fault_done cycle
    cur_tag = "R8";
    mem_lat = 2;
    send(32'hFFC0_3000, 1'b1);
    while (!fault_pending) @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0040_1000; req_write = 1'b0;
    repeat (4) @(negedge clk);
    check("R8", "ready_during_hold", {31'b0, req_ready}, 32'd0);
    fault_done = 1'b1;
    @(negedge clk);
    fault_done = 1'b0;
    check("R8", "fault_rsp", {31'b0, rsp_valid & rsp_fault}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    finish_walk();
    @(negedge clk);

    // R10: stray fault_done and a request held during a walk
    cur_tag = "R10";
    fault_done = 1'b1;
    @(negedge clk);
    fault_done = 1'b0;
    @(negedge clk);
    check("R10", "stray_done_pending", {31'b0, fault_pending}, 32'd0);
    req_valid = 1'b1; req_addr = 32'h0040_1ABC; req_write = 1'b1;
    repeat (15) @(negedge clk);
    req_valid = 1'b0;
    finish_walk();
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule